// File: doc/BRIEF.md
# Mixed-Width Asynchronous Show-Ahead FIFO

This block carries a byte stream from one clock domain to an unrelated one. Bytes enter on the write clock, and the read side delivers them as 32-bit words. Four bytes make one word, and the first byte of a group sits in the least significant lane. Storage holds 2048 bytes, which is 512 read words. Each domain has its own synchronous active-low reset.

The read port works in show-ahead form. Whenever at least one complete word is stored, the oldest such word is already on `rd_data`. Asserting `rd_req` consumes that word, and the next word appears after the following read clock edge. A read word becomes visible only after all four of its bytes have been written. A request that would overflow or underflow is dropped and leaves the pointers as they are.

Each side computes its own flags and fill count from its own pointer and a synchronised copy of the other side's pointer. The pointers cross between domains in Gray code through two-stage synchronisers, so a count seen on the far side never jumps by more than the real progress. Both request inputs are assumed to be synchronous to their own clocks.

Top module: `mixed_width_async_fifo`

## Requirements
- R1: After both resets are released, `rd_empty` and `wr_empty` are 1, `rd_full` and `wr_full` are 0, and `rd_used` and `wr_used` are 0.
- R2: Byte lanes: the first byte written to a word lands in `rd_data[7:0]`, the second in `[15:8]`, the third in `[23:16]` and the fourth in `[31:24]`.
- R3: Show-ahead: while `rd_empty` is 0, `rd_data` already holds the oldest unread word with no request given. A read clock edge with `rd_req`=1 moves the output to the next word.
- R4: A word becomes readable only once its fourth byte has been written. `rd_used` counts complete 32-bit words, from 0 to 512.
- R5: `wr_full` is 1 when 2048 bytes are held. `rd_full` is 1 and `rd_used` is 512 once all 512 words are visible to the read side. `rd_used` never exceeds 512.
- R6: A write request while `wr_full` is 1 is discarded: the write pointer and the stored data do not change.
- R7: A read request while `rd_empty` is 1 is discarded: the read pointer does not move, so later data comes out in order.
- R8: `wr_used` equals the bytes written minus four times the words read, as seen from the write side, in the range 0 to 2048. `wr_empty` is 1 exactly when this count is 0.
- R9: Pointers cross domains glitch-free. Each Gray pointer changes by at most one bit per cycle of its own clock, and `rd_used` never decreases in a cycle that consumed no word.
- R10: Under concurrent traffic on unrelated clocks, every word read equals the next four accepted bytes in write order. After draining, both sides report empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_req | input | 1 | Write request, sampled on rising `wr_clk` |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | No room for another byte |
| wr_empty | output | 1 | Write side sees no stored bytes |
| wr_used | output | 12 | Bytes held, as seen by the write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_req | input | 1 | Consume the word shown on `rd_data` |
| rd_data | output | 32 | Oldest complete unread word (show-ahead) |
| rd_empty | output | 1 | No complete word available |
| rd_full | output | 1 | All 512 words visible to the read side |
| rd_used | output | 10 | Complete words held, as seen by the read side |

## Verification
The hardest state to reach from the ports is a full FIFO that meets further write requests, and in particular reaching full while the reader is also active, so that overflow protection is tested while the read pointer is crossing domains. The stimulus first fills the store with a directed burst while reads are held off, then issues extra writes carrying a marker byte, and then drains the store word by word against the byte model. A random phase then runs the writer near its full rate against a sparse reader, so that the full flag is reached repeatedly with both clocks active. After that the reader rate is raised until the FIFO empties, and underflow requests are issued at the empty boundary.

// File: rtl/mwf_pkg.sv
// Package: Gray-code helpers shared by the mixed-width FIFO.
// Assumes pointer widths of at most 32 bits; callers zero-extend and slice.
package mwf_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary (prefix XOR from the top).
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/mwf_sync.sv
// Two-stage synchroniser for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock, so any
// sample is either the old or the new value. Synchronous active-low reset.
module mwf_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the foreign pointer through two flops of the local clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/mwf_store.sv
// Byte-write, word-read storage. It is split into RATIO lanes of WR_W bits.
// A byte goes to the lane picked by the low address bits, so lane 0
// holds the first byte of each word. The read is combinational to give a
// show-ahead output. Assumes RATIO is a power of two and at least 2.
module mwf_store #(
    parameter int WR_W  = 8,
    parameter int RATIO = 4,
    parameter int WORDS = 512,
    localparam int SHIFT = $clog2(RATIO),
    localparam int WAW   = $clog2(WORDS),
    localparam int BAW   = WAW + SHIFT
) (
    input  logic                  wr_clk,
    input  logic                  we,
    input  logic [BAW-1:0]        waddr,
    input  logic [WR_W-1:0]       wdata,
    input  logic [WAW-1:0]        raddr,
    output logic [WR_W*RATIO-1:0] rdata
);

    for (genvar l = 0; l < RATIO; l++) begin : g_lane
        logic [WR_W-1:0] lane_mem [WORDS];

        // Store the byte when the write address selects this lane.
        always_ff @(posedge wr_clk) begin
            if (we && (waddr[SHIFT-1:0] == SHIFT'(l))) begin
                lane_mem[waddr[BAW-1:SHIFT]] <= wdata;
            end
        end

        assign rdata[l*WR_W +: WR_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/mwf_wr_ctl.sv
// Write-side control. It keeps a byte pointer one bit wider than the
// address and publishes the pointer of completed words in Gray code from
// a flop. It computes full, empty and the byte count against the
// synchronised read word pointer. A write while full is dropped.
module mwf_wr_ctl
    import mwf_pkg::*;
#(
    parameter int BPW   = 12,
    parameter int WPW   = 10,
    parameter int SHIFT = 2,
    parameter int DEPTH = 2048
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [WPW-1:0] rgray_s,
    output logic           we,
    output logic           full,
    output logic           empty,
    output logic [BPW-1:0] used,
    output logic [BPW-1:0] ptr,
    output logic [WPW-1:0] gray
);

    logic [WPW-1:0] rword;
    logic [BPW-1:0] rbyte;
    logic [BPW-1:0] ptr_nxt;

    // Decode the far pointer and derive occupancy in bytes.
    always_comb begin
        rword   = WPW'(from_gray(32'(rgray_s)));
        rbyte   = {rword, {SHIFT{1'b0}}};
        used    = ptr - rbyte;
        full    = (used == BPW'(DEPTH));
        empty   = (used == '0);
        we      = req && !full;
        ptr_nxt = ptr + BPW'(we);
    end

    // Advance the byte pointer and register the Gray word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            gray <= '0;
        end else begin
            ptr  <= ptr_nxt;
            gray <= WPW'(to_gray(32'(ptr_nxt[BPW-1:SHIFT])));
        end
    end

endmodule

// File: rtl/mwf_rd_ctl.sv
// Read-side control. It keeps a word pointer one bit wider than the word
// address and compares it with the synchronised write pointer, which only
// counts completed words. A read while empty is dropped.
module mwf_rd_ctl
    import mwf_pkg::*;
#(
    parameter int WPW   = 10,
    parameter int WORDS = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [WPW-1:0] wgray_s,
    output logic           empty,
    output logic           full,
    output logic [WPW-1:0] used,
    output logic [WPW-1:0] ptr,
    output logic [WPW-1:0] gray
);

    logic [WPW-1:0] wword;
    logic [WPW-1:0] ptr_nxt;
    logic           take;

    // Decode the far pointer and derive occupancy in words.
    always_comb begin
        wword   = WPW'(from_gray(32'(wgray_s)));
        used    = wword - ptr;
        empty   = (used == '0);
        full    = (used == WPW'(WORDS));
        take    = req && !empty;
        ptr_nxt = ptr + WPW'(take);
    end

    // Advance the word pointer and register its Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            gray <= '0;
        end else begin
            ptr  <= ptr_nxt;
            gray <= WPW'(to_gray(32'(ptr_nxt)));
        end
    end

endmodule

// File: rtl/mixed_width_async_fifo.sv
// Top: dual-clock FIFO taking WR_W-bit bytes and giving RATIO-byte words in
// show-ahead form. Assumes wr_req and rd_req are synchronous to their own
// clocks, DEPTH and RATIO are powers of two, and RATIO is at least 2.
module mixed_width_async_fifo #(
    parameter int WR_W  = 8,
    parameter int RATIO = 4,
    parameter int DEPTH = 2048,
    localparam int RD_W  = WR_W * RATIO,
    localparam int WORDS = DEPTH / RATIO,
    localparam int BAW   = $clog2(DEPTH),
    localparam int WAW   = $clog2(WORDS),
    localparam int SHIFT = $clog2(RATIO)
) (
    input  logic            wr_clk,
    input  logic            wr_rst_n,
    input  logic            wr_req,
    input  logic [WR_W-1:0] wr_data,
    output logic            wr_full,
    output logic            wr_empty,
    output logic [BAW:0]    wr_used,
    input  logic            rd_clk,
    input  logic            rd_rst_n,
    input  logic            rd_req,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_empty,
    output logic            rd_full,
    output logic [WAW:0]    rd_used
);

    logic           we;
    logic [BAW:0]   wptr;
    logic [WAW:0]   wgray;
    logic [WAW:0]   wgray_s;
    logic [WAW:0]   rptr;
    logic [WAW:0]   rgray;
    logic [WAW:0]   rgray_s;

    mwf_wr_ctl #(
        .BPW  (BAW + 1),
        .WPW  (WAW + 1),
        .SHIFT(SHIFT),
        .DEPTH(DEPTH)
    ) u_wr (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .req    (wr_req),
        .rgray_s(rgray_s),
        .we     (we),
        .full   (wr_full),
        .empty  (wr_empty),
        .used   (wr_used),
        .ptr    (wptr),
        .gray   (wgray)
    );

    mwf_sync #(.W(WAW + 1)) u_r2w (
        .clk  (wr_clk),
        .rst_n(wr_rst_n),
        .d    (rgray),
        .q    (rgray_s)
    );

    mwf_sync #(.W(WAW + 1)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .d    (wgray),
        .q    (wgray_s)
    );

    mwf_rd_ctl #(
        .WPW  (WAW + 1),
        .WORDS(WORDS)
    ) u_rd (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .req    (rd_req),
        .wgray_s(wgray_s),
        .empty  (rd_empty),
        .full   (rd_full),
        .used   (rd_used),
        .ptr    (rptr),
        .gray   (rgray)
    );

    mwf_store #(
        .WR_W (WR_W),
        .RATIO(RATIO),
        .WORDS(WORDS)
    ) u_store (
        .wr_clk(wr_clk),
        .we    (we),
        .waddr (wptr[BAW-1:0]),
        .wdata (wr_data),
        .raddr (rptr[WAW-1:0]),
        .rdata (rd_data)
    );

endmodule

// File: rtl/mwf_checker.sv
// Checker: temporal properties of the mixed-width FIFO, bound to the top.
// Assumes each reset is held for at least two cycles of its own clock.
module mwf_checker #(
    parameter int BPW   = 12,
    parameter int WPW   = 10,
    parameter int WORDS = 512
) (
    input logic           wr_clk,
    input logic           wr_rst_n,
    input logic           wr_req,
    input logic           wr_full,
    input logic [BPW-1:0] wptr,
    input logic [WPW-1:0] wgray,
    input logic           rd_clk,
    input logic           rd_rst_n,
    input logic           rd_req,
    input logic           rd_empty,
    input logic [WPW-1:0] rd_used,
    input logic [WPW-1:0] rptr,
    input logic [WPW-1:0] rgray
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge rd_clk)
        $rose(rd_rst_n) |-> rd_empty);  // R1

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && wr_req) |=> (wptr == $past(wptr)));  // R6

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_empty && rd_req) |=> (rptr == $past(rptr)));  // R7

    AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);  // R9

    AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);  // R9

    AST_RD_USED_NO_DROP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(rd_req && !rd_empty) |=> (rd_used >= $past(rd_used)));  // R9

    AST_RD_USED_LIMIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_used <= WPW'(WORDS));  // R5

endmodule

bind mixed_width_async_fifo mwf_checker #(
    .BPW  (BAW + 1),
    .WPW  (WAW + 1),
    .WORDS(WORDS)
) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .wr_req  (wr_req),
    .wr_full (wr_full),
    .wptr    (wptr),
    .wgray   (wgray),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .rd_req  (rd_req),
    .rd_empty(rd_empty),
    .rd_used (rd_used),
    .rptr    (rptr),
    .rgray   (rgray)
);

// File: tb/mixed_width_async_fifo_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, with a byte
// queue as the reference model. Inputs change on negative edges.
module mixed_width_async_fifo_test;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_req = 1'b0;
    logic        wr_full, wr_empty, rd_empty, rd_full;
    logic [11:0] wr_used;
    logic [9:0]  rd_used;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model[$];

    always #2.5  wr_clk = ~wr_clk;
    always #1.85 rd_clk = ~rd_clk;

    mixed_width_async_fifo uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .wr_full(wr_full), .wr_empty(wr_empty), .wr_used(wr_used),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_full(rd_full), .rd_used(rd_used)
    );

    // Expected word: the four oldest model bytes, first byte in the low lane.
    function automatic logic [31:0] head_word();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cycle(input bit en, input logic [7:0] d);
        @(negedge wr_clk);
        wr_req  = en;
        wr_data = d;
        if (en && !wr_full) model.push_back(d);
    endtask

    task automatic rd_cycle(input bit en);
        @(negedge rd_clk);
        rd_req = en;
        if (en && !rd_empty) begin
            if (model.size() < 4) chk("R10 model underrun", 32'(model.size()), 32'd4);
            else begin
                chk("R10 R3 read word", rd_data, head_word());
                repeat (4) void'(model.pop_front());
            end
        end
    endtask

    task automatic settle();
        @(negedge wr_clk); wr_req = 1'b0;
        @(negedge rd_clk); rd_req = 1'b0;
        repeat (8) @(negedge wr_clk);
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        @(negedge rd_clk);
        // R1: reset state on both sides
        chk("R1 rd_empty", 32'(rd_empty), 32'd1);
        chk("R1 rd_full", 32'(rd_full), 32'd0);
        chk("R1 rd_used", 32'(rd_used), 32'd0);
        @(negedge wr_clk);
        chk("R1 wr_empty", 32'(wr_empty), 32'd1);
        chk("R1 wr_full", 32'(wr_full), 32'd0);
        chk("R1 wr_used", 32'(wr_used), 32'd0);

        // R4: three bytes do not make a readable word
        wr_cycle(1, 8'h11); wr_cycle(1, 8'h22); wr_cycle(1, 8'h33);
        settle();
        chk("R4 partial rd_empty", 32'(rd_empty), 32'd1);
        chk("R4 partial rd_used", 32'(rd_used), 32'd0);
        chk("R8 partial wr_used", 32'(wr_used), 32'd3);
        chk("R8 partial wr_empty", 32'(wr_empty), 32'd0);
        wr_cycle(1, 8'h44);
        settle();
        chk("R4 complete rd_used", 32'(rd_used), 32'd1);
        chk("R2 R3 lanes shown ahead", rd_data, 32'h44332211);
        rd_cycle(1);
        settle();
        chk("R3 advance rd_empty", 32'(rd_empty), 32'd1);
        chk("R8 drained wr_used", 32'(wr_used), 32'd0);
        chk("R8 drained wr_empty", 32'(wr_empty), 32'd1);

        // R7: reads while empty are ignored
        for (int i = 0; i < 5; i++) rd_cycle(1);
        settle();
        chk("R7 rd_used after underflow", 32'(rd_used), 32'd0);
        chk("R7 rd_empty after underflow", 32'(rd_empty), 32'd1);
        for (int i = 0; i < 4; i++) wr_cycle(1, 8'hA0 + 8'(i));
        settle();
        chk("R7 data order after underflow", rd_data, 32'hA3A2A1A0);
        chk("R7 rd_used after refill", 32'(rd_used), 32'd1);
        rd_cycle(1);
        settle();

        // R5/R6: fill to capacity, then push past it
        for (int i = 0; i < 2048; i++) wr_cycle(1, 8'($urandom));
        settle();
        chk("R5 wr_full", 32'(wr_full), 32'd1);
        chk("R5 rd_full", 32'(rd_full), 32'd1);
        chk("R5 rd_used", 32'(rd_used), 32'd512);
        chk("R8 full wr_used", 32'(wr_used), 32'd2048);
        for (int i = 0; i < 6; i++) wr_cycle(1, 8'hEE);
        settle();
        chk("R6 wr_used after overflow", 32'(wr_used), 32'd2048);
        chk("R6 model size", 32'(model.size()), 32'd2048);
        chk("R3 head while full", rd_data, head_word());
        for (int i = 0; i < 512; i++) rd_cycle(1);
        settle();
        chk("R6 empty after drain", 32'(rd_empty), 32'd1);
        chk("R8 wr_used after drain", 32'(wr_used), 32'd0);

        // R10: concurrent random traffic, reader sparse then dense
        fork
            begin
                for (int i = 0; i < 6000; i++)
                    wr_cycle(($urandom % 100) < 90, 8'($urandom));
                @(negedge wr_clk); wr_req = 1'b0;
            end
            begin
                for (int i = 0; i < 9000; i++)
                    rd_cycle(($urandom % 100) < ((i < 4500) ? 5 : 70));
                @(negedge rd_clk); rd_req = 1'b0;
            end
        join
        settle();
        chk("R9 rd_used vs model", 32'(rd_used), 32'(model.size() / 4));
        chk("R8 wr_used vs model", 32'(wr_used), 32'(model.size()));
        while (!rd_empty) rd_cycle(1);
        for (int i = 0; i < 3; i++) rd_cycle(1);
        settle();
        chk("R10 leftover bytes", 32'(model.size() % 4), 32'(wr_used));
        while (model.size() % 4 != 0) wr_cycle(1, 8'h5A);
        settle();
        while (!rd_empty) rd_cycle(1);
        settle();
        chk("R10 model empty", 32'(model.size()), 32'd0);
        chk("R10 rd_empty", 32'(rd_empty), 32'd1);
        chk("R10 wr_empty", 32'(wr_empty), 32'd1);
        finish_run();
    end

endmodule